// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block relays the memory operand of a numeric-coprocessor escape instruction between system memory and the coprocessor. The instruction decoder pulses `start` together with the first operand byte address, the number of 16-bit words and the direction. The sequencer is then armed. While armed, it turns the coprocessor's transfer request into a series of bus commands for a bus unit. Every word passes through a single fixed I/O data port and a holding register inside the block. The block works out every address and the read/write sense of every command itself. The coprocessor only says when it wants service.

An even-aligned word takes one 16-bit memory access and one I/O access. A word that starts at an odd byte address is split into two byte-wide memory accesses, so it takes three bus operations. The bus unit sees a plain command/done handshake. A command stays valid with stable fields until the bus unit returns a one-cycle `bus_done`. After the last operation of the last word, the sequencer pulses `xfer_done` and goes back to idle.

Top module: `cop_xfer_seq`

## Requirements
- R1: During and right after reset, `bus_cmd_valid`, `busy` and `xfer_done` are low.
- R2: While the sequencer is not armed, `cop_req` has no effect and no bus command is issued. A `start` pulse with a nonzero `word_cnt` arms it, and `busy` is high while it is armed.
- R3: Every coprocessor data access is an I/O command (`bus_cmd_io`=1) to address 0x00FA with `bus_cmd_be`=2'b11 and a full 16-bit word.
- R4: With `to_cop`=1, each word is first read from memory and then written by an I/O write to 0x00FA. The I/O write carries the memory word, with the byte at the lower address in bits 7:0.
- R5: With `to_cop`=0, each word is first read from port 0x00FA with an I/O read and then written to memory. Bits 7:0 of the port word land at the lower byte address.
- R6: A word at an even address takes exactly two bus operations. Its memory operation uses the word address with `bus_cmd_be`=2'b11.
- R7: A word at odd address A takes exactly three bus operations. Its low byte is accessed first at address A with `bus_cmd_be`=2'b10, on data lane 15:8. Its high byte follows at A+1 with `bus_cmd_be`=2'b01, on lane 7:0. On a byte write, the byte is driven on both lanes.
- R8: The memory address of word k is the start address plus 2k.
- R9: Once `bus_cmd_valid` rises, it stays high and the address, byte enables and direction stay stable until the cycle in which `bus_done` is sampled high. The next command comes no earlier than the following cycle.
- R10: When `cop_req` is low, the command in flight still completes, but no new command starts until `cop_req` is high again. The transfer then resumes where it stopped.
- R11: `xfer_done` is a one-cycle pulse in the cycle after the final operation completes, and `busy` falls at the same time. A `start` with `word_cnt`=0 issues no command and pulses `xfer_done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse from the decoder that loads the operand description |
| start_addr | input | ADDR_W | Byte address of the first operand word |
| word_cnt | input | CNT_W | Number of 16-bit words to move |
| to_cop | input | 1 | 1: memory to coprocessor; 0: coprocessor to memory |
| cop_req | input | 1 | Transfer request from the coprocessor |
| busy | output | 1 | Sequencer armed for a transfer |
| xfer_done | output | 1 | One-cycle pulse after the last word |
| bus_cmd_valid | output | 1 | Bus command pending |
| bus_cmd_io | output | 1 | 1: I/O space; 0: memory space |
| bus_cmd_write | output | 1 | 1: write; 0: read |
| bus_cmd_addr | output | ADDR_W | Byte address of the command |
| bus_cmd_be | output | 2 | Byte-lane enables (bit 0 = lane 7:0) |
| bus_cmd_wdata | output | 16 | Write data |
| bus_done | input | 1 | Bus unit completes the pending command |
| bus_rdata | input | 16 | Read data, valid with `bus_done` |

## Verification
The bench sweeps both directions, both start-address parities and one to three words. Each time it compares the full command log against a list of operations computed from the start address. A design that swapped the byte order on an odd word, or put a byte on the wrong lane, would leave scrambled bytes in memory or at the port. A design that forgot the split would log two operations where three are expected. The bench also drops `cop_req` right after one operation in the middle of a word, and expects silence followed by a clean resume. A sequencer that ignored the request would keep issuing commands, and one that lost its place would repeat or skip an operation. Zero-length transfers and requests that arrive before arming check that nothing reaches the bus when it should not.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        K_MEM_FULL,
        K_MEM_LO,
        K_MEM_HI,
        K_IO
    } op_kind_e;

    typedef enum logic {
        S_IDLE,
        S_ARMED
    } seq_st_e;
endpackage

// File: rtl/cop_xfer_plan.sv
module cop_xfer_plan
    import cop_xfer_pkg::*;
(
    input  logic [1:0] idx,
    input  logic       to_cop,
    input  logic       odd,
    output op_kind_e   kind,
    output logic       last
);
    // Position of each operation inside one word, per direction and alignment
    always_comb begin
        kind = K_IO;
        last = 1'b0;
        if (to_cop) begin
            case (idx)
                2'd0:    kind = odd ? K_MEM_LO : K_MEM_FULL;
                2'd1: begin
                    kind = odd ? K_MEM_HI : K_IO;
                    last = !odd;
                end
                default: begin
                    kind = K_IO;
                    last = 1'b1;
                end
            endcase
        end else begin
            case (idx)
                2'd0:    kind = K_IO;
                2'd1: begin
                    kind = odd ? K_MEM_LO : K_MEM_FULL;
                    last = !odd;
                end
                default: begin
                    kind = K_MEM_HI;
                    last = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/cop_xfer_lane.sv
module cop_xfer_lane
    import cop_xfer_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] IO_PORT = 'h00FA
) (
    input  op_kind_e           kind,
    input  logic               to_cop,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [WORD_W-1:0]  hold,
    input  logic [WORD_W-1:0]  rdata,
    output logic               cmd_io,
    output logic               cmd_write,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [1:0]         cmd_be,
    output logic [WORD_W-1:0]  cmd_wdata,
    output logic [WORD_W-1:0]  hold_nx
);
    localparam int HB = WORD_W / 2;

    always_comb begin
        cmd_io    = (kind == K_IO);
        cmd_write = (kind == K_IO) ? to_cop : !to_cop;
        case (kind)
            K_MEM_FULL: begin
                cmd_addr  = cur_addr;
                cmd_be    = 2'b11;
                cmd_wdata = hold;
                hold_nx   = rdata;
            end
            K_MEM_LO: begin
                // odd address: the byte sits on the upper lane
                cmd_addr  = cur_addr;
                cmd_be    = 2'b10;
                cmd_wdata = {hold[HB-1:0], hold[HB-1:0]};
                hold_nx   = {hold[WORD_W-1:HB], rdata[WORD_W-1:HB]};
            end
            K_MEM_HI: begin
                cmd_addr  = cur_addr + ADDR_W'(1);
                cmd_be    = 2'b01;
                cmd_wdata = {hold[WORD_W-1:HB], hold[WORD_W-1:HB]};
                hold_nx   = {rdata[HB-1:0], hold[HB-1:0]};
            end
            default: begin
                cmd_addr  = IO_PORT;
                cmd_be    = 2'b11;
                cmd_wdata = hold;
                hold_nx   = rdata;
            end
        endcase
    end
endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
    import cop_xfer_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                CNT_W   = 8,
    parameter logic [ADDR_W-1:0] IO_PORT = 'h00FA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              to_cop,
    input  logic              cop_req,
    output logic              busy,
    output logic              xfer_done,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_io,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [1:0]        bus_cmd_be,
    output logic [15:0]       bus_cmd_wdata,
    input  logic              bus_done,
    input  logic [15:0]       bus_rdata
);
    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic              to_cop;
        logic [1:0]        idx;
        logic              valid;
        logic [WORD_W-1:0] hold;
        logic              done;
    } seq_t;

    seq_t r_d, r_q;

    op_kind_e          kind;
    logic              last_op;
    logic [WORD_W-1:0] hold_nx;

    cop_xfer_plan plan_i (
        .idx    (r_q.idx),
        .to_cop (r_q.to_cop),
        .odd    (r_q.addr[0]),
        .kind   (kind),
        .last   (last_op)
    );

    cop_xfer_lane #(
        .ADDR_W  (ADDR_W),
        .IO_PORT (IO_PORT)
    ) lane_i (
        .kind      (kind),
        .to_cop    (r_q.to_cop),
        .cur_addr  (r_q.addr),
        .hold      (r_q.hold),
        .rdata     (bus_rdata),
        .cmd_io    (bus_cmd_io),
        .cmd_write (bus_cmd_write),
        .cmd_addr  (bus_cmd_addr),
        .cmd_be    (bus_cmd_be),
        .cmd_wdata (bus_cmd_wdata),
        .hold_nx   (hold_nx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.addr   = start_addr;
                    r_d.left   = word_cnt;
                    r_d.to_cop = to_cop;
                    r_d.idx    = 2'd0;
                    r_d.valid  = 1'b0;
                    if (word_cnt == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = S_ARMED;
                    end
                end
            end
            default: begin
                if (!r_q.valid) begin
                    r_d.valid = cop_req;
                end else if (bus_done) begin
                    r_d.valid = 1'b0;
                    if (!bus_cmd_write) begin
                        r_d.hold = hold_nx;
                    end
                    if (last_op) begin
                        r_d.idx  = 2'd0;
                        r_d.addr = r_q.addr + ADDR_W'(2);
                        r_d.left = r_q.left - 1'b1;
                        if (r_q.left == CNT_W'(1)) begin
                            r_d.st   = S_IDLE;
                            r_d.done = 1'b1;
                        end
                    end else begin
                        r_d.idx = r_q.idx + 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st == S_ARMED);
    assign xfer_done     = r_q.done;
    assign bus_cmd_valid = r_q.valid;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && !bus_done |=> bus_cmd_valid && $stable(bus_cmd_addr)
            && $stable(bus_cmd_be) && $stable(bus_cmd_write)); // R9
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && bus_done |=> !bus_cmd_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_cmd_valid); // R2
    AST_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cmd_valid && !cop_req |=> !bus_cmd_valid); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R11
    AST_IO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && bus_cmd_io |-> bus_cmd_addr == IO_PORT && bus_cmd_be == 2'b11); // R3
    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && !bus_cmd_io && bus_cmd_be != 2'b11 |-> bus_cmd_be[0] != bus_cmd_be[1]); // R7
endmodule

// File: tb/cop_xfer_seq_tb.sv
`timescale 1ns/1ps
module cop_xfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] start_addr;
    logic [7:0]  word_cnt;
    logic        to_cop;
    logic        cop_req;
    logic        busy, xfer_done;
    logic        bus_cmd_valid, bus_cmd_io, bus_cmd_write;
    logic [15:0] bus_cmd_addr;
    logic [1:0]  bus_cmd_be;
    logic [15:0] bus_cmd_wdata;
    logic        bus_done;
    logic [15:0] bus_rdata;

    always #2.5 clk = ~clk;

    cop_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_cnt(word_cnt), .to_cop(to_cop), .cop_req(cop_req),
        .busy(busy), .xfer_done(xfer_done), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_io(bus_cmd_io), .bus_cmd_write(bus_cmd_write),
        .bus_cmd_addr(bus_cmd_addr), .bus_cmd_be(bus_cmd_be),
        .bus_cmd_wdata(bus_cmd_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata)
    );

    logic [7:0]  mem [0:255];
    logic [15:0] cop_src [0:7];
    logic [15:0] cop_dst [0:7];
    int src_i, dst_i;
    logic        lg_io [0:31];
    logic        lg_wr [0:31];
    logic [15:0] lg_addr [0:31];
    logic [1:0]  lg_be [0:31];
    logic [15:0] lg_wd [0:31];
    int op_cnt, done_cnt, wait_n, cycles;
    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // bus unit and memory responder
    initial begin
        bus_done = 1'b0; bus_rdata = '0; op_cnt = 0; done_cnt = 0; wait_n = 0;
        src_i = 0; dst_i = 0;
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            if (bus_cmd_valid) begin
                if (wait_n < (op_cnt % 3)) begin
                    wait_n++;
                end else begin
                    logic [7:0] b;
                    b = bus_cmd_addr[7:0] & 8'hFE;
                    wait_n = 0;
                    if (op_cnt < 32) begin
                        lg_io[op_cnt] = bus_cmd_io; lg_wr[op_cnt] = bus_cmd_write;
                        lg_addr[op_cnt] = bus_cmd_addr; lg_be[op_cnt] = bus_cmd_be;
                        lg_wd[op_cnt] = bus_cmd_wdata;
                    end
                    if (bus_cmd_io) begin
                        if (bus_cmd_write) begin cop_dst[dst_i[2:0]] = bus_cmd_wdata; dst_i++; end
                        else begin bus_rdata = cop_src[src_i[2:0]]; src_i++; end
                    end else if (bus_cmd_write) begin
                        if (bus_cmd_be[0]) mem[b] = bus_cmd_wdata[7:0];
                        if (bus_cmd_be[1]) mem[b + 8'd1] = bus_cmd_wdata[15:8];
                    end else begin
                        bus_rdata = {mem[b + 8'd1], mem[b]};
                    end
                    bus_done = 1'b1;
                    op_cnt++;
                end
            end
            if (xfer_done) done_cnt++;
        end
    end

    // watchdog
    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    task automatic prep(input logic [15:0] a);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        for (int w = 0; w < 8; w++) cop_src[w] = 16'hC35A ^ 16'(w * 16'h1111) ^ a;
        op_cnt = 0; src_i = 0; dst_i = 0; wait_n = 0;
    endtask

    task automatic wait_done(input int d0);
        int t;
        t = 0;
        while (done_cnt == d0 && t < 500) begin @(negedge clk); t++; end
    endtask

    // compare log and data against arithmetic expectation
    task automatic verify(input bit dir, input logic [15:0] a0, input int n, input int d0);
        int m, per;
        logic [7:0] init [0:255];
        for (int i = 0; i < 256; i++) init[i] = 8'(i * 7 + 3);
        m   = a0[0] ? 2 : 1;
        per = m + 1;
        chk(op_cnt == n * per, a0[0] ? "R7 op count" : "R6 op count", op_cnt, n * per);
        chk(done_cnt == d0 + 1, "R11 single done", done_cnt, d0 + 1);
        chk(!busy, "R11 busy low after done", busy, 0);
        for (int w = 0; w < n && w < 3; w++) begin
            logic [15:0] a;
            int p, io_p, mem_p;
            a     = a0 + 16'(2 * w);
            p     = w * per;
            io_p  = dir ? p + m : p;
            mem_p = dir ? p : p + 1;
            chk({lg_io[io_p], lg_wr[io_p], lg_addr[io_p], lg_be[io_p]} == {1'b1, dir, 16'h00FA, 2'b11},
                dir ? "R3 R4 io op" : "R3 R5 io op",
                {lg_io[io_p], lg_wr[io_p], lg_addr[io_p], lg_be[io_p]}, {1'b1, dir, 16'h00FA, 2'b11});
            if (m == 1) begin
                chk({lg_io[mem_p], lg_wr[mem_p], lg_addr[mem_p], lg_be[mem_p]} == {1'b0, !dir, a, 2'b11},
                    "R6 R8 word op", {lg_io[mem_p], lg_wr[mem_p], lg_addr[mem_p], lg_be[mem_p]},
                    {1'b0, !dir, a, 2'b11});
            end else begin
                chk({lg_io[mem_p], lg_wr[mem_p], lg_addr[mem_p], lg_be[mem_p]} == {1'b0, !dir, a, 2'b10},
                    "R7 R8 low byte op", {lg_io[mem_p], lg_wr[mem_p], lg_addr[mem_p], lg_be[mem_p]},
                    {1'b0, !dir, a, 2'b10});
                chk({lg_io[mem_p+1], lg_wr[mem_p+1], lg_addr[mem_p+1], lg_be[mem_p+1]} == {1'b0, !dir, a + 16'd1, 2'b01},
                    "R7 high byte op", {lg_io[mem_p+1], lg_wr[mem_p+1], lg_addr[mem_p+1], lg_be[mem_p+1]},
                    {1'b0, !dir, a + 16'd1, 2'b01});
                if (!dir)
                    chk(lg_wd[mem_p] == {cop_src[w][7:0], cop_src[w][7:0]}, "R7 byte on both lanes",
                        lg_wd[mem_p], {cop_src[w][7:0], cop_src[w][7:0]});
            end
            if (dir)
                chk(cop_dst[w] == {init[a[7:0] + 8'd1], init[a[7:0]]}, "R4 word to port",
                    cop_dst[w], {init[a[7:0] + 8'd1], init[a[7:0]]});
            else
                chk({mem[a[7:0] + 8'd1], mem[a[7:0]]} == cop_src[w], "R5 word to memory",
                    {mem[a[7:0] + 8'd1], mem[a[7:0]]}, cop_src[w]);
        end
    endtask

    task automatic kick(input bit dir, input logic [15:0] a, input int n, input bit req);
        @(negedge clk);
        start = 1'b1; start_addr = a; word_cnt = 8'(n); to_cop = dir; cop_req = req;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        int d0;
        logic [15:0] a;
        rst_n = 1'b0; start = 1'b0; start_addr = '0; word_cnt = '0; to_cop = 1'b0; cop_req = 1'b0;
        repeat (4) @(negedge clk);
        chk({bus_cmd_valid, busy, xfer_done} == 3'b000, "R1 reset outputs", {bus_cmd_valid, busy, xfer_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_cmd_valid, busy, xfer_done} == 3'b000, "R1 after reset", {bus_cmd_valid, busy, xfer_done}, 0);

        // R2: request before arming is ignored
        prep(16'h0);
        cop_req = 1'b1;
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 8; i++) begin @(negedge clk); seen |= bus_cmd_valid; end
            chk(!seen && op_cnt == 0, "R2 request ignored while idle", {seen, 8'(op_cnt)}, 0);
        end

        // sweep: direction x parity x length
        for (int dir = 0; dir < 2; dir++)
            for (int off = 0; off < 2; off++)
                for (int n = 1; n <= 3; n++) begin
                    a = 16'h0030 + 16'(16 * n) + 16'(off);
                    prep(a);
                    d0 = done_cnt;
                    kick(dir[0], a, n, 1'b1);
                    chk(busy, "R2 armed after start", busy, 1);
                    wait_done(d0);
                    @(negedge clk);
                    verify(dir[0], a, n, d0);
                end

        // R11: zero-length transfer
        prep(16'h0);
        @(negedge clk);
        start = 1'b1; start_addr = 16'h0050; word_cnt = 8'd0; cop_req = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(xfer_done && !busy, "R11 zero count done", {xfer_done, busy}, 2'b10);
        @(negedge clk);
        chk(!xfer_done && op_cnt == 0, "R11 zero count no ops", {xfer_done, 8'(op_cnt)}, 0);

        // R10: pause and resume mid-word
        a = 16'h0081;
        prep(a);
        d0 = done_cnt;
        kick(1'b1, a, 2, 1'b0);
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= bus_cmd_valid; end
            chk(!seen && op_cnt == 0, "R10 armed but no request", {seen, 8'(op_cnt)}, 0);
            cop_req = 1'b1;
            while (op_cnt < 1) @(posedge clk);
            @(negedge clk);
            cop_req = 1'b0;
            seen = 1'b0;
            for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= bus_cmd_valid; end
            chk(!seen && op_cnt == 1, "R10 paused after current op", {seen, 8'(op_cnt)}, 1);
            cop_req = 1'b1;
        end
        wait_done(d0);
        @(negedge clk);
        verify(1'b1, a, 2, d0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule